// File: doc/BRIEF.md
# Byte-Addressed Element-Width Register File

This block holds 128 general-purpose 64-bit registers and treats the whole store as one flat array of 1024 bytes. Every access names a base register, an element width code and an element offset. The access then selects a packed element of 8, 16, 32 or 64 bits. A vector loop that walks the offset upward fills or drains consecutive registers, starting at the base register, without gaps. Because of this, an element with a large enough offset lives in a register above its base.

There are two independent read ports and one write port, and each port has its own width code. A write changes only the bytes that belong to the addressed element. The rest of the register keeps its contents, so a short vector leaves the tail of its last register intact. A scalar write bypasses the element addressing and replaces the whole base register. Reads are synchronous: the element appears, zero-extended, in the cycle after its address. The storage is eight byte-wide banks, one per byte lane, and each bank is indexed separately, so an FPGA can map the banks to RAM.

Top module: `elw_regfile`

## Requirements
- R1: The width code selects the element size: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits and 3 (the default) gives 64 bits.
- R2: An element starts at byte address base*8 + offset*(element bytes). The store is little-endian: byte b of a register holds bits 8b+7:8b. An element whose offset runs past its base register is taken from the following registers.
- R3: Byte addresses wrap modulo 1024. For example, offset 4 of 16-bit elements at base 127 addresses bytes 0 and 1 of register 0.
- R4: A non-scalar write changes exactly the bytes of the addressed element. After 8-bit writes at offsets 0 to 6 of a register, byte 7 of that register keeps its earlier value.
- R5: When the scalar flag is set on a write, the width code and offset are ignored and all 64 bits of the base register are replaced.
- R6: A read returns the element in the low bits of the 64-bit output, with all higher bits zero.
- R7: Read data appears on the output after the first rising clock edge that follows the address. If a read and a write to the same bytes happen in the same cycle, the read returns the data from before the write.
- R8: Both read ports and the write port take their width codes, bases and offsets independently, and can use them in the same cycle.
- R9: While reset is high at a clock edge, both read outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_scalar | input | 1 | Write the full base register and ignore the width code and offset |
| wr_base | input | 7 | Write base register |
| wr_wcode | input | 2 | Write width code |
| wr_ofs | input | 10 | Write element offset |
| wr_data | input | 64 | Write element, right-aligned |
| ra_base | input | 7 | Port A base register |
| ra_wcode | input | 2 | Port A width code |
| ra_ofs | input | 10 | Port A element offset |
| ra_data | output | 64 | Port A element, zero-extended |
| rb_base | input | 7 | Port B base register |
| rb_wcode | input | 2 | Port B width code |
| rb_ofs | input | 10 | Port B element offset |
| rb_data | output | 64 | Port B element, zero-extended |

## Verification
The assertions assume that the width code, base and offset inputs are never unknown while a write is strobed or a read is in flight. They also assume that wr_data carries the element right-aligned; any bits above the element are don't-care. The stimulus drives every control input to a defined value from the first cycle. It sets write-only inputs only in the cycle that carries the write strobe. Offsets are kept within the 10-bit field, so wrapping is exercised only through the modulo-1024 byte address.

// File: rtl/elw_pkg.sv
package elw_pkg;
  // width codes: element bytes = 1 << code
  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ew_e;

  localparam logic [1:0] EW_DEFAULT = EW64;
endpackage

// File: rtl/elw_addr_gen.sv
module elw_addr_gen #(
  parameter int NREGS  = 128,
  parameter int LANES  = 8,
  parameter int RIDX_W = $clog2(NREGS),
  parameter int LSEL_W = $clog2(LANES),
  parameter int OFS_W  = RIDX_W + LSEL_W
) (
  input  logic                             scalar,
  input  logic [RIDX_W-1:0]                base,
  input  logic [1:0]                       wcode,
  input  logic [OFS_W-1:0]                 ofs,
  output logic [LSEL_W-1:0]                lane_start,
  output logic [LANES-1:0][RIDX_W-1:0]     rows,
  output logic [LANES-1:0]                 lane_en
);
  import elw_pkg::*;
  localparam int BADDR_W = RIDX_W + LSEL_W;

  logic [1:0]         wc_eff;
  logic [BADDR_W-1:0] step;
  logic [BADDR_W-1:0] byte_addr;
  logic [LSEL_W:0]    nbytes;

  // scalar forces a full-register access at offset zero
  always_comb begin
    wc_eff    = scalar ? EW_DEFAULT : wcode;
    step      = scalar ? '0 : (BADDR_W'(ofs) << wc_eff);
    byte_addr = {base, {LSEL_W{1'b0}}} + step;  // wraps over the whole store
    nbytes    = (LSEL_W+1)'(1) << wc_eff;
  end

  assign lane_start = byte_addr[LSEL_W-1:0];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LSEL_W-1:0]  k;   // element byte index carried by lane j
    logic [BADDR_W-1:0] a;
    always_comb begin
      k          = LSEL_W'(j) - byte_addr[LSEL_W-1:0];
      a          = byte_addr + BADDR_W'(k);
      rows[j]    = a[BADDR_W-1:LSEL_W];
      lane_en[j] = ({1'b0, k} < nbytes);
    end
  end
endmodule

// File: rtl/elw_byte_bank.sv
module elw_byte_bank #(
  parameter int NREGS  = 128,
  parameter int RIDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RIDX_W-1:0] wrow,
  input  logic [7:0]        wbyte,
  input  logic [RIDX_W-1:0] arow,
  input  logic [RIDX_W-1:0] brow,
  output logic [7:0]        aq,
  output logic [7:0]        bq
);
  logic [7:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (we) mem[wrow] <= wbyte;
  end

  // registered read ports, read-before-write
  always_ff @(posedge clk) begin
    if (rst) begin
      aq <= '0;
      bq <= '0;
    end else begin
      aq <= mem[arow];
      bq <= mem[brow];
    end
  end
endmodule

// File: rtl/elw_read_align.sv
module elw_read_align #(
  parameter int LANES  = 8,
  parameter int LSEL_W = $clog2(LANES)
) (
  input  logic [LANES-1:0][7:0] lanes_q,
  input  logic [LSEL_W-1:0]     start,
  input  logic [1:0]            wcode,
  output logic [8*LANES-1:0]    data
);
  logic [LSEL_W:0] nbytes;
  assign nbytes = (LSEL_W+1)'(1) << wcode;

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    logic [LSEL_W-1:0] src;
    always_comb begin
      src = start + LSEL_W'(k);
      data[8*k +: 8] = ((LSEL_W+1)'(k) < nbytes) ? lanes_q[src] : 8'h00;
    end
  end
endmodule

// File: rtl/elw_regfile.sv
module elw_regfile #(
  parameter int NREGS = 128,
  parameter int LANES = 8,
  localparam int RIDX_W = $clog2(NREGS),
  localparam int LSEL_W = $clog2(LANES),
  localparam int OFS_W  = RIDX_W + LSEL_W,
  localparam int DATA_W = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_scalar,
  input  logic [RIDX_W-1:0] wr_base,
  input  logic [1:0]        wr_wcode,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [RIDX_W-1:0] ra_base,
  input  logic [1:0]        ra_wcode,
  input  logic [OFS_W-1:0]  ra_ofs,
  output logic [DATA_W-1:0] ra_data,
  input  logic [RIDX_W-1:0] rb_base,
  input  logic [1:0]        rb_wcode,
  input  logic [OFS_W-1:0]  rb_ofs,
  output logic [DATA_W-1:0] rb_data
);
  logic [LSEL_W-1:0]            wr_start, ra_start, rb_start;
  logic [LANES-1:0][RIDX_W-1:0] wr_rows, ra_rows, rb_rows;
  logic [LANES-1:0]             wr_lane_en, ra_lane_en, rb_lane_en;
  logic [LANES-1:0][7:0]        ra_lanes, rb_lanes;
  logic [LSEL_W-1:0]            ra_start_q, rb_start_q;
  logic [1:0]                   ra_w_q, rb_w_q;

  elw_addr_gen #(.NREGS(NREGS), .LANES(LANES)) u_wag (
    .scalar(wr_scalar), .base(wr_base), .wcode(wr_wcode), .ofs(wr_ofs),
    .lane_start(wr_start), .rows(wr_rows), .lane_en(wr_lane_en));

  elw_addr_gen #(.NREGS(NREGS), .LANES(LANES)) u_aag (
    .scalar(1'b0), .base(ra_base), .wcode(ra_wcode), .ofs(ra_ofs),
    .lane_start(ra_start), .rows(ra_rows), .lane_en(ra_lane_en));

  elw_addr_gen #(.NREGS(NREGS), .LANES(LANES)) u_bag (
    .scalar(1'b0), .base(rb_base), .wcode(rb_wcode), .ofs(rb_ofs),
    .lane_start(rb_start), .rows(rb_rows), .lane_en(rb_lane_en));

  for (genvar j = 0; j < LANES; j++) begin : g_bank
    logic [LSEL_W-1:0] wk;
    logic [7:0]        wbyte;
    always_comb begin
      wk    = LSEL_W'(j) - wr_start;
      wbyte = wr_data[8*wk +: 8];
    end
    elw_byte_bank #(.NREGS(NREGS)) u_bank (
      .clk(clk), .rst(rst),
      .we(wr_en & wr_lane_en[j]), .wrow(wr_rows[j]), .wbyte(wbyte),
      .arow(ra_rows[j]), .brow(rb_rows[j]),
      .aq(ra_lanes[j]), .bq(rb_lanes[j]));
  end

  // alignment state travels with the bank read
  always_ff @(posedge clk) begin
    if (rst) begin
      ra_start_q <= '0;
      rb_start_q <= '0;
      ra_w_q     <= '0;
      rb_w_q     <= '0;
    end else begin
      ra_start_q <= ra_start;
      rb_start_q <= rb_start;
      ra_w_q     <= ra_wcode;
      rb_w_q     <= rb_wcode;
    end
  end

  elw_read_align #(.LANES(LANES)) u_aal (
    .lanes_q(ra_lanes), .start(ra_start_q), .wcode(ra_w_q), .data(ra_data));

  elw_read_align #(.LANES(LANES)) u_bal (
    .lanes_q(rb_lanes), .start(rb_start_q), .wcode(rb_w_q), .data(rb_data));

  function automatic logic [DATA_W-1:0] elem_mask(input logic [1:0] c);
    return {DATA_W{1'b1}} >> (DATA_W - (8 << c));
  endfunction

  // R4: byte enables issued to the banks match the element size
  assert_wr_byte_count_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_scalar) |-> ($countones(wr_lane_en) == (1 << wr_wcode)));

  // R5: scalar write drives every lane of the base register
  assert_scalar_full_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_scalar) |-> ((wr_lane_en == '1) && (wr_rows == {LANES{wr_base}})));

  // R6: nothing above the element reaches the outputs
  assert_zero_ext_R6: assert property (@(posedge clk) disable iff (rst)
    ((ra_data & ~elem_mask(ra_w_q)) == '0) && ((rb_data & ~elem_mask(rb_w_q)) == '0));

  // R1: read lane selection covers as many bytes as the width code names
  assert_rd_lanes_R1: assert property (@(posedge clk) disable iff (rst)
    ($countones(ra_lane_en) == (1 << ra_wcode)) && ($countones(rb_lane_en) == (1 << rb_wcode)));
endmodule

// File: tb/sim_elw_regfile.sv
`timescale 1ns/1ps
module sim_elw_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_scalar = 1'b0;
  logic [6:0]  wr_base = '0, ra_base = '0, rb_base = '0;
  logic [1:0]  wr_wcode = '0, ra_wcode = '0, rb_wcode = '0;
  logic [9:0]  wr_ofs = '0, ra_ofs = '0, rb_ofs = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] ra_data, rb_data;

  always #2 clk = ~clk;  // 250 MHz

  elw_regfile u0 (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_scalar(wr_scalar), .wr_base(wr_base), .wr_wcode(wr_wcode),
    .wr_ofs(wr_ofs), .wr_data(wr_data),
    .ra_base(ra_base), .ra_wcode(ra_wcode), .ra_ofs(ra_ofs), .ra_data(ra_data),
    .rb_base(rb_base), .rb_wcode(rb_wcode), .rb_ofs(rb_ofs), .rb_data(rb_data));

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [1024];

  typedef struct packed {
    logic        rd;
    logic [6:0]  base;
    logic [1:0]  wc;
    logic [9:0]  ofs;
    logic [63:0] data;
  } op_t;

  localparam int NOPS = 14;
  localparam op_t TBL [NOPS] = '{
    '{1'b0, 7'd10,  2'd0, 10'd3,   64'h00000000000000AB},
    '{1'b1, 7'd10,  2'd3, 10'd0,   64'h0},
    '{1'b0, 7'd20,  2'd1, 10'd5,   64'h000000000000BEEF},
    '{1'b1, 7'd21,  2'd3, 10'd0,   64'h0},
    '{1'b1, 7'd20,  2'd1, 10'd5,   64'h0},
    '{1'b0, 7'd30,  2'd2, 10'd3,   64'h00000000DEADBEEF},
    '{1'b1, 7'd31,  2'd2, 10'd1,   64'h0},
    '{1'b1, 7'd30,  2'd0, 10'd12,  64'h0},
    '{1'b0, 7'd40,  2'd3, 10'd2,   64'h0123456789ABCDEF},
    '{1'b1, 7'd42,  2'd3, 10'd0,   64'h0},
    '{1'b1, 7'd40,  2'd2, 10'd5,   64'h0},
    '{1'b0, 7'd0,   2'd0, 10'd1023, 64'h0000000000000077},
    '{1'b1, 7'd127, 2'd3, 10'd0,   64'h0},
    '{1'b1, 7'd64,  2'd1, 10'd3,   64'h0}
  };

  function automatic int baddr(input logic [6:0] b, input logic [1:0] wc, input logic [9:0] o);
    return (int'(b) * 8 + int'(o) * (1 << wc)) % 1024;
  endfunction

  function automatic logic [63:0] mdl_read(input logic [6:0] b, input logic [1:0] wc, input logic [9:0] o);
    logic [63:0] r = '0;
    int a = baddr(b, wc, o);
    for (int k = 0; k < (1 << wc); k++) r[8*k +: 8] = mdl[(a + k) % 1024];
    return r;
  endfunction

  task automatic mdl_write(input logic sc, input logic [6:0] b, input logic [1:0] wc,
                           input logic [9:0] o, input logic [63:0] d);
    int a = sc ? int'(b) * 8 : baddr(b, wc, o);
    int n = sc ? 8 : (1 << wc);
    for (int k = 0; k < n; k++) mdl[(a + k) % 1024] = d[8*k +: 8];
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sc, input logic [6:0] b, input logic [1:0] wc,
                    input logic [9:0] o, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_scalar = sc; wr_base = b; wr_wcode = wc; wr_ofs = o; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_scalar = 1'b0;
    mdl_write(sc, b, wc, o, d);
  endtask

  task automatic rda(input logic [6:0] b, input logic [1:0] wc, input logic [9:0] o,
                     output logic [63:0] q);
    @(negedge clk);
    ra_base = b; ra_wcode = wc; ra_ofs = o;
    @(negedge clk);
    q = ra_data;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] q, qb, old;
    repeat (3) @(negedge clk);
    chk("R9 reset port A", ra_data, 64'h0);
    chk("R9 reset port B", rb_data, 64'h0);
    rst = 1'b0;

    for (int i = 0; i < 128; i++)
      wr(1'b1, 7'(i), 2'd0, 10'd0, {8{8'(i)}} ^ 64'hF0E1D2C3B4A59687);

    // stimulus table, reads compared against the byte model (R2)
    for (int i = 0; i < NOPS; i++) begin
      if (TBL[i].rd) begin
        rda(TBL[i].base, TBL[i].wc, TBL[i].ofs, q);
        chk($sformatf("R2 table entry %0d", i), q, mdl_read(TBL[i].base, TBL[i].wc, TBL[i].ofs));
      end else begin
        wr(1'b0, TBL[i].base, TBL[i].wc, TBL[i].ofs, TBL[i].data);
      end
    end

    // R4: seven byte writes leave byte 7 alone
    wr(1'b1, 7'd5, 2'd0, 10'd0, 64'h1122334455667788);
    for (int k = 0; k < 7; k++) wr(1'b0, 7'd5, 2'd0, 10'(k), 64'(8'hE0 + k));
    rda(7'd5, 2'd3, 10'd0, q);
    chk("R4 byte 7 kept", q, 64'h11E6E5E4E3E2E1E0);

    // R6 / R1 / R2 on that register
    rda(7'd5, 2'd0, 10'd7, q);
    chk("R6 8-bit zero-extended", q, 64'h11);
    rda(7'd5, 2'd2, 10'd1, q);
    chk("R6 32-bit zero-extended", q, 64'h11E6E5E4);
    rda(7'd5, 2'd1, 10'd3, q);
    chk("R1 16-bit element", q, 64'h11E6);
    rda(7'd4, 2'd0, 10'd15, q);
    chk("R2 offset spills past base", q, 64'h11);

    // R5: scalar write ignores width code and offset
    old = mdl_read(7'd7, 2'd3, 10'd0);
    wr(1'b1, 7'd6, 2'd0, 10'd9, 64'hCAFEF00D12345678);
    rda(7'd6, 2'd3, 10'd0, q);
    chk("R5 scalar full register", q, 64'hCAFEF00D12345678);
    rda(7'd7, 2'd3, 10'd0, q);
    chk("R5 offset target untouched", q, old);

    // R3: byte address wraps to register 0
    wr(1'b1, 7'd0, 2'd0, 10'd0, 64'h0);
    wr(1'b0, 7'd127, 2'd1, 10'd4, 64'h5AA5);
    rda(7'd0, 2'd3, 10'd0, q);
    chk("R3 wrap to register 0", q, 64'h5AA5);
    rda(7'd127, 2'd1, 10'd4, q);
    chk("R3 wrapped read back", q, 64'h5AA5);

    // R7: read-before-write in the same cycle
    wr(1'b1, 7'd9, 2'd0, 10'd0, 64'h0102030405060708);
    @(negedge clk);
    wr_en = 1'b1; wr_scalar = 1'b1; wr_base = 7'd9; wr_data = 64'hFFEEDDCCBBAA9988;
    ra_base = 7'd9; ra_wcode = 2'd3; ra_ofs = 10'd0;
    @(negedge clk);
    wr_en = 1'b0; wr_scalar = 1'b0;
    chk("R7 same-cycle read sees old", ra_data, 64'h0102030405060708);
    @(negedge clk);
    chk("R7 next read sees new", ra_data, 64'hFFEEDDCCBBAA9988);
    mdl_write(1'b1, 7'd9, 2'd0, 10'd0, 64'hFFEEDDCCBBAA9988);

    // R8: two ports, different widths, same cycle
    @(negedge clk);
    ra_base = 7'd9; ra_wcode = 2'd3; ra_ofs = 10'd0;
    rb_base = 7'd9; rb_wcode = 2'd0; rb_ofs = 10'd2;
    @(negedge clk);
    q = ra_data; qb = rb_data;
    chk("R8 port A 64-bit", q, 64'hFFEEDDCCBBAA9988);
    chk("R8 port B 8-bit", qb, 64'hAA);

    // R9: reset clears outputs mid-run
    rst = 1'b1;
    @(negedge clk);
    chk("R9 mid-run reset A", ra_data, 64'h0);
    chk("R9 mid-run reset B", rb_data, 64'h0);
    rst = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule